// File: doc/BRIEF.md
# Sample-queue pulse-width modulator

This block produces one pulse-width modulated output whose high time is taken from a short queue of duty samples. Software writes a period value, a divide ratio for the count clock and a control word, then streams duty samples into a four-word queue. A counter steps once per prescaled tick. Each time it wraps, the generator either uses the current sample again or takes the next one from the queue. The control word sets how many periods each sample lasts. If the queue has run dry, the last sample stays in use and a sticky starvation flag is raised.

Access is through a plain synchronous register port with four word addresses. Address 0 is the control word, 1 is the status word, 2 is the sample queue and 3 is the period. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. A control state machine has three states. `ST_OFF` holds the output low. `ST_RUN` counts and drives the waveform. `ST_SWRST` is a timed soft reset that flushes the queue. `ST_OFF` goes to `ST_RUN` once the stored enable bit is 1. `ST_RUN` goes back to `ST_OFF` once the enable bit is 0. A control write with the reset bit set sends either of those states to `ST_SWRST`. `ST_SWRST` returns to `ST_OFF` after `RST_CYCLES` clocks.

The clock-source and low-power bits of the control word are only stored and read back. They have no effect on the waveform.

Top module: `pwm_fifo_gen`

## Requirements
- R1: One period is min(P, 0xFFFE) + 2 ticks, where P is the period register at address 3. The counter runs from 0 up to that limit minus 1. A P of 0xFFFF gives a period of 65536 ticks, the same as 0xFFFE.
- R2: Control bits 15:4 hold the prescaler field N. One tick lasts N + 1 clock cycles, so N = 0 advances the counter on every clock.
- R3: Control bits 19:18 select the output mode. 0 drives the output high while the count is below the sample S and low otherwise. 1 drives the inverse of mode 0. 2 and 3 hold the output low.
- R4: Writes to address 2 enter a four-entry queue. Status bits 2:0 report how many entries it holds, from 0 to 4.
- R5: A write to address 2 while the queue holds 4 entries is dropped and the level stays 4. It also sets the sticky write-error flag in status bit 6.
- R6: Control bits 2:1 set how many periods each sample lasts: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The next sample is taken at the wrap after the last of those periods. The first sample is taken when running starts.
- R7: If a new sample is due and the queue is empty, the previous sample stays in use and the sticky status bit 3 is set.
- R8: While control bit 0 (enable) is 0, `pwm_out` is 0 whatever the mode.
- R9: A control write with bit 3 set clears the control, period and status registers and empties the queue. Control bit 3 then reads as 1 for 4 clock cycles (`RST_CYCLES`) and reads 0 afterwards.
- R10: Status bit 4 (roll-over) is set at every counter wrap. Status bit 5 (compare) is set on a tick where the count equals the sample. Bits 6:3 are sticky and clear when 1 is written to them at address 1.
- R11: A read of address 2 returns the sample in use while the block runs with enable set, and 0 otherwise.
- R12: A new period or prescaler value is picked up only at the next counter wrap. The period already in progress keeps its length.
- R13: Register word addresses are 0 for control, 1 for status, 2 for samples and 3 for period. Read data is combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume at most one register access per cycle. They also assume that `bus_addr` and `bus_wdata` are stable around the clock edge while `bus_wr` is high. The write-drop property further assumes that no soft reset coincides with the sample write it looks at. The bench meets these assumptions by changing the port inputs only at falling edges and by holding the write strobe for exactly one cycle per access. It also waits for the soft reset to finish before it issues the next write.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    // control word field positions
    localparam int CTL_EN      = 0;
    localparam int CTL_REP_LO  = 1;
    localparam int CTL_SWR     = 3;
    localparam int CTL_PRE_LO  = 4;
    localparam int CTL_PRE_W   = 12;
    localparam int CTL_MODE_LO = 18;
    localparam int CTL_W       = 32;

    // status word flag positions
    localparam int STS_STARVE = 3;
    localparam int STS_ROV    = 4;
    localparam int STS_CMP    = 5;
    localparam int STS_WERR   = 6;

    typedef enum logic [1:0] {
        ADR_CTRL   = 2'd0,
        ADR_STAT   = 2'd1,
        ADR_SAMPLE = 2'd2,
        ADR_PERIOD = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SWRST = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        OUT_SET_CLR = 2'd0,
        OUT_CLR_SET = 2'd1,
        OUT_HELD    = 2'd2,
        OUT_HELD_B  = 2'd3
    } out_mode_e;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pwm_wave_engine.sv
module pwm_wave_engine #(
    parameter int PER_W = 16,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             clr,
    input  logic [PER_W-1:0] per_cfg,
    input  logic [PRE_W-1:0] pre_cfg,
    input  logic [1:0]       rep_sel,
    input  logic             fifo_empty,
    input  logic [PER_W-1:0] fifo_data,
    output logic             pop,
    output logic             wrap_ev,
    output logic             cmp_ev,
    output logic             starve_ev,
    output logic             raw_hi,
    output logic [PER_W-1:0] duty_q
);
    localparam int CNT_W = PER_W + 1;
    localparam logic [PER_W-1:0] PER_CAP = {{(PER_W-1){1'b1}}, 1'b0};

    logic [CNT_W-1:0] cnt_q, cnt_lim;
    logic [PER_W-1:0] per_sh, per_eff;
    logic [PRE_W-1:0] pre_sh, pdiv_q;
    logic [2:0]       rep_q, rep_lim;
    logic             tick, rep_done, need;

    always_comb begin
        per_eff   = (per_sh > PER_CAP) ? PER_CAP : per_sh;
        cnt_lim   = CNT_W'(per_eff) + CNT_W'(1);
        tick      = run && (pdiv_q == pre_sh);
        wrap_ev   = tick && (cnt_q == cnt_lim);
        rep_lim   = 3'((4'd1 << rep_sel) - 4'd1);
        rep_done  = (rep_q == rep_lim);
        need      = start || (wrap_ev && rep_done);
        pop       = need && !fifo_empty;
        starve_ev = need && fifo_empty;
        cmp_ev    = tick && (cnt_q == CNT_W'(duty_q));
        raw_hi    = cnt_q < CNT_W'(duty_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pdiv_q <= '0;
            per_sh <= '0;
            pre_sh <= '0;
            rep_q  <= '0;
            duty_q <= '0;
        end else begin
            if (start) begin
                cnt_q  <= '0;
                pdiv_q <= '0;
                per_sh <= per_cfg;
                pre_sh <= pre_cfg;
                rep_q  <= '0;
            end else if (run) begin
                if (tick) begin
                    pdiv_q <= '0;
                    if (wrap_ev) begin
                        cnt_q  <= '0;
                        per_sh <= per_cfg;
                        pre_sh <= pre_cfg;
                        rep_q  <= rep_done ? 3'd0 : rep_q + 3'd1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end else begin
                    pdiv_q <= pdiv_q + PRE_W'(1);
                end
            end
            if (clr)      duty_q <= '0;
            else if (pop) duty_q <= fifo_data;
        end
    end
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int PER_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int RC_W  = $clog2(RST_CYCLES + 1);

    run_state_e        st_q, st_d;
    reg_addr_e         adr;
    logic [CTL_W-1:0]  ctrl_q;
    logic [PER_W-1:0]  per_q;
    logic [RC_W-1:0]   rst_cnt_q;
    logic              werr_q, cmp_q, rov_q, starve_q;
    logic              wr_ctrl, wr_stat, wr_sample, wr_period, swr_req;
    logic              run, start, flush, busy;
    logic              ctrl_en;
    logic [1:0]        out_mode;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full, fifo_empty;
    logic [PER_W-1:0]  fifo_dout, duty;
    logic              eng_pop, eng_wrap, eng_cmp, eng_starve, raw_hi;

    assign adr       = reg_addr_e'(bus_addr);
    assign ctrl_en   = ctrl_q[CTL_EN];
    assign out_mode  = ctrl_q[CTL_MODE_LO +: 2];
    assign wr_ctrl   = bus_wr && (adr == ADR_CTRL)   && (st_q != ST_SWRST);
    assign wr_stat   = bus_wr && (adr == ADR_STAT)   && (st_q != ST_SWRST);
    assign wr_sample = bus_wr && (adr == ADR_SAMPLE) && (st_q != ST_SWRST);
    assign wr_period = bus_wr && (adr == ADR_PERIOD) && (st_q != ST_SWRST);
    assign swr_req   = wr_ctrl && bus_wdata[CTL_SWR];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:   if (swr_req) st_d = ST_SWRST;
                      else if (ctrl_en) st_d = ST_RUN;
            ST_RUN:   if (swr_req) st_d = ST_SWRST;
                      else if (!ctrl_en) st_d = ST_OFF;
            ST_SWRST: if (rst_cnt_q == RC_W'(RST_CYCLES - 1)) st_d = ST_OFF;
            default:  st_d = ST_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        run   = (st_q == ST_RUN);
        busy  = (st_q == ST_SWRST);
        start = (st_q == ST_OFF) && (st_d == ST_RUN);
        flush = busy || swr_req;
        if (!run || !ctrl_en) begin
            pwm_out = 1'b0;
        end else begin
            unique case (out_mode_e'(out_mode))
                OUT_SET_CLR: pwm_out = raw_hi;
                OUT_CLR_SET: pwm_out = !raw_hi;
                default:     pwm_out = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rst_cnt_q <= '0;
        else if (st_q != ST_SWRST) rst_cnt_q <= '0;
        else                     rst_cnt_q <= rst_cnt_q + RC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            per_q    <= '0;
            werr_q   <= 1'b0;
            cmp_q    <= 1'b0;
            rov_q    <= 1'b0;
            starve_q <= 1'b0;
        end else if (swr_req) begin
            ctrl_q   <= '0;
            per_q    <= '0;
            werr_q   <= 1'b0;
            cmp_q    <= 1'b0;
            rov_q    <= 1'b0;
            starve_q <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl_q <= bus_wdata;
            if (wr_period) per_q  <= bus_wdata[PER_W-1:0];
            werr_q   <= (wr_sample && fifo_full) || (werr_q   && !(wr_stat && bus_wdata[STS_WERR]));
            cmp_q    <= eng_cmp                  || (cmp_q    && !(wr_stat && bus_wdata[STS_CMP]));
            rov_q    <= eng_wrap                 || (rov_q    && !(wr_stat && bus_wdata[STS_ROV]));
            starve_q <= eng_starve               || (starve_q && !(wr_stat && bus_wdata[STS_STARVE]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (adr)
            ADR_CTRL: begin
                bus_rdata          = ctrl_q;
                bus_rdata[CTL_SWR] = busy;
            end
            ADR_STAT: begin
                bus_rdata[LVL_W-1:0]  = fifo_level;
                bus_rdata[STS_STARVE] = starve_q;
                bus_rdata[STS_ROV]    = rov_q;
                bus_rdata[STS_CMP]    = cmp_q;
                bus_rdata[STS_WERR]   = werr_q;
            end
            ADR_SAMPLE: if (run && ctrl_en) bus_rdata[PER_W-1:0] = duty;
            ADR_PERIOD: bus_rdata[PER_W-1:0] = per_q;
            default:    bus_rdata = '0;
        endcase
    end

    pwm_sample_fifo #(.W(PER_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (wr_sample && !fifo_full),
        .din   (bus_wdata[PER_W-1:0]),
        .pop   (eng_pop),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_wave_engine #(.PER_W(PER_W), .PRE_W(CTL_PRE_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .start      (start),
        .clr        (flush),
        .per_cfg    (per_q),
        .pre_cfg    (ctrl_q[CTL_PRE_LO +: CTL_PRE_W]),
        .rep_sel    (ctrl_q[CTL_REP_LO +: 2]),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_dout),
        .pop        (eng_pop),
        .wrap_ev    (eng_wrap),
        .cmp_ev     (eng_cmp),
        .starve_ev  (eng_starve),
        .raw_hi     (raw_hi),
        .duty_q     (duty)
    );
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             ctrl_en,
    input logic [1:0]       out_mode,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             busy,
    input logic             flush,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_pop,
    input logic             werr,
    input logic             wrap_ev,
    input logic             rov
);
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !pwm_out);                                             // R8

    AST_HELD_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode[1] |-> !pwm_out);                                          // R3

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));                                       // R4

    AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !busy && fifo_level == LVL_W'(DEPTH) && !fifo_pop)
        |=> (fifo_level == LVL_W'(DEPTH) && werr));                         // R5

    AST_SWRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> fifo_level == '0);                                         // R9

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_ev && !flush) |=> rov);                                       // R10
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .ctrl_en    (ctrl_en),
    .out_mode   (out_mode),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .busy       (busy),
    .flush      (flush),
    .fifo_level (fifo_level),
    .fifo_pop   (eng_pop),
    .werr       (werr_q),
    .wrap_ev    (eng_wrap),
    .rov        (rov_q)
);

// File: tb/tb_pwm_fifo_gen.sv
module tb_pwm_fifo_gen;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 4;
    localparam int WATCHDOG   = 190000;

    // {period[61:46], prescale[45:34], mode[33:32], sample[31:16], expected high clocks[15:0]}
    localparam logic [61:0] VEC [0:8] = '{
        {16'd8,  12'd0, 2'd0, 16'd3, 16'd3},
        {16'd8,  12'd0, 2'd1, 16'd3, 16'd7},
        {16'd5,  12'd2, 2'd0, 16'd4, 16'd12},
        {16'd10, 12'd0, 2'd2, 16'd5, 16'd0},
        {16'd4,  12'd0, 2'd0, 16'd9, 16'd6},
        {16'd6,  12'd1, 2'd0, 16'd0, 16'd0},
        {16'd0,  12'd0, 2'd0, 16'd1, 16'd1},
        {16'd3,  12'd3, 2'd1, 16'd2, 16'd12},
        {16'd7,  12'd0, 2'd3, 16'd4, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int h, n, n2;
    logic [31:0] d;

    pwm_fifo_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic blk(input int len, output int hi);
        hi = 0;
        repeat (len) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(output int cnt);
        logic prev;
        cnt  = 0;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            cnt++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic soft_reset();
        wr(2'd0, 32'h8);
        repeat (RST_CYC + 1) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R13 addresses, R8 output low)
        rd(2'd0, d); check("R13 ctrl reset", d, 32'h0);
        rd(2'd1, d); check("R4 status reset", d, 32'h0);
        rd(2'd3, d); check("R13 period reset", d, 32'h0);
        rd(2'd2, d); check("R11 sample read while off", d, 32'h0);
        check("R8 output low after reset", {31'b0, pwm_out}, 32'h0);

        // queue fill, overflow and write-one-clear
        wr(2'd2, 32'd11); wr(2'd2, 32'd12); wr(2'd2, 32'd13);
        rd(2'd1, d); check("R4 level three", d, 32'h3);
        wr(2'd2, 32'd14); wr(2'd2, 32'd15);
        rd(2'd1, d); check("R5 overflow dropped, error flag", d, 32'h44);
        wr(2'd1, 32'h40);
        rd(2'd1, d); check("R10 write-one-clear of bit 6", d, 32'h4);

        // soft reset
        wr(2'd3, 32'd9);
        wr(2'd0, 32'h0000_0008);
        rd(2'd0, d); check("R9 reset bit reads one", d, 32'h8);
        rd(2'd1, d); check("R9 queue flushed", d, 32'h0);
        repeat (RST_CYC) @(negedge clk);
        rd(2'd0, d); check("R9 reset bit self clears", d, 32'h0);
        rd(2'd3, d); check("R9 period cleared", d, 32'h0);

        // table of waveform vectors (R1 R2 R3)
        for (int i = 0; i < 9; i++) begin
            logic [15:0] p, s, e;
            logic [11:0] pre;
            logic [1:0]  md;
            p   = VEC[i][61:46];
            pre = VEC[i][45:34];
            md  = VEC[i][33:32];
            s   = VEC[i][31:16];
            e   = VEC[i][15:0];
            soft_reset();
            wr(2'd3, {16'd0, p});
            wr(2'd2, {16'd0, s});
            wr(2'd0, (32'(md) << 18) | (32'(pre) << 4) | 32'h1);
            repeat (3) @(negedge clk);
            blk((int'(p) + 2) * (int'(pre) + 1), h);
            check($sformatf("R3 R1 R2 vector %0d high clocks", i), h, 32'(e));
            if (i == 0) begin
                rd(2'd2, d); check("R11 sample readback while running", d, 32'd3);
                rd(2'd1, d); check("R10 roll-over and compare flags", d & 32'h30, 32'h30);
            end
        end

        // repeat count and starvation (R6 R7)
        soft_reset();
        wr(2'd3, 32'd6);
        wr(2'd2, 32'd2);
        wr(2'd2, 32'd5);
        wr(2'd0, 32'h3);
        wait_rise(n);
        blk(8, h); check("R6 period 1 uses first sample", h, 32'd2);
        blk(8, h); check("R6 period 2 repeats first sample", h, 32'd2);
        blk(8, h); check("R6 period 3 uses second sample", h, 32'd5);
        blk(8, h); check("R6 period 4 repeats second sample", h, 32'd5);
        rd(2'd1, d); check("R7 starvation flag set", d & 32'h8, 32'h8);
        rd(2'd2, d); check("R11 readback of held sample", d, 32'd5);
        blk(8, h); check("R7 last sample kept", h, 32'd5);

        // inverted mode while running, then disable (R3 R8)
        wr(2'd0, (32'd1 << 18) | 32'h3);
        blk(8, h); check("R3 inverted output", h, 32'd3);
        wr(2'd0, (32'd1 << 18));
        blk(10, h); check("R8 disabled output low in inverted mode", h, 32'd0);
        rd(2'd2, d); check("R11 sample read while disabled", d, 32'h0);
        wr(2'd1, 32'h78);
        rd(2'd1, d); check("R10 all sticky flags cleared", d, 32'h0);

        // period change lands at the boundary (R12)
        soft_reset();
        wr(2'd3, 32'd6);
        wr(2'd2, 32'd2);
        wr(2'd0, 32'h1);
        wait_rise(n);
        wr(2'd3, 32'd10);
        wait_rise(n2);
        check("R12 current period keeps old length", n2 + 1, 32'd8);
        wait_rise(n2);
        check("R12 next period uses new value", n2, 32'd12);

        // 0xFFFF behaves as 0xFFFE (R1)
        soft_reset();
        wr(2'd3, 32'hFFFF);
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h1);
        wait_rise(n);
        wait_rise(n2);
        check("R1 capped period length", n2, 32'd65536);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule